// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a memory-mapped watchdog timer with two escalation steps. Software programs a 48-bit timeout period and sets an enable bit. The block then computes a deadline from a free-running 64-bit system count supplied by the surrounding chip. If software does not refresh the timer before the deadline, the block raises an interrupt and arms a second deadline one period later. If that second deadline also passes, the block raises a reset request.

Two register windows are decoded with separate chip selects. The refresh window has one job: software writes to it to keep the timer alive. The control window holds these registers:

- the enable bit and the two stage flags;
- the two halves of the period;
- a 64-bit compare word, which software can read and write;
- an identification word.

The compare word records the deadline set by the most recent explicit refresh. The live deadline is held in a separate internal register. All accesses are aligned 32-bit words.

Top module: `wdog_two_stage`

## Requirements
- R1: The period is 48 bits. The low word is at control offset 0x008. The high word is at control offset 0x00C and keeps only bits [15:0] of the written data, so it reads back with bits [31:16] zero.
- R2: An explicit refresh loads both the internal deadline and the visible compare word with the system count plus the 48-bit period, but only when the enable bit is set after the write. An explicit refresh is any of these writes: the refresh register, the control/status register, or either period word. The compare word is split into a low word at 0x010 and a high word at 0x014.
- R3: When the enabled timer reaches its deadline (system count ≥ deadline) while flag bit 1 is clear, the block does three things in the next cycle. It sets that flag, asserts `irq`, and re-arms the deadline at count plus period. The compare word is left unchanged.
- R4: When the enabled timer reaches its deadline while flag bit 1 is already set, the block sets flag bit 2, and `rst_req` goes high.
- R5: A write with any data to the refresh register (refresh window offset 0x000) clears both flags and drops `rst_req`. It leaves `irq` unchanged.
- R6: Writes to the compare words only store the data. They do not change the flags, `irq`, or the live deadline.
- R7: While the enable bit is clear, no timeout occurs, whatever the system count.
- R8: A read of the refresh register returns zero and has no side effect. The identification word at offset 0xFCC can be read from either window.
- R9: Block reset clears the control/status register, both period words, both compare words, `irq` and `rst_req`.
- R10: A control/status write at offset 0x000 keeps only data bit 0 as the enable bit, clears both flags, and deasserts `irq`. The register reads back with enable in bit 0, the first-stage flag in bit 1 and the second-stage flag in bit 2.
- R11: A write to either period word clears both flags, deasserts `irq`, and performs an explicit refresh that uses the new period.
- R12: Reads from undefined offsets return zero, and writes to undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_cnt | input | 64 | Free-running system count |
| rf_sel | input | 1 | Selects the refresh window |
| cf_sel | input | 1 | Selects the control window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset within the selected window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; combinational, zero when no read is active |
| irq | output | 1 | First-stage timeout interrupt |
| rst_req | output | 1 | Second-stage reset request |

## Verification
The timer is driven by setting the system count to exactly one count below a deadline and then exactly at it. This separates the ≥ comparison from an off-by-one error, and the first stage from the second.

A count and period whose sum carries out of the low word show whether the 64-bit add and the 48-bit period join correctly. Writing the compare word with a value far below the count shows whether the live deadline is truly independent of the visible compare word.

Sweeping the count to a very large value with the timer disabled, and writing to undefined offsets, confirms that these stimuli cause no action.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter logic [31:0] ID_WORD = 32'h0002_0A57,
  parameter int          AW      = 12,
  parameter int          CW      = 64,
  parameter int          PHW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sys_cnt,
  input  logic          rf_sel,
  input  logic          cf_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [AW-1:0] A_CTL = AW'('h000);
  localparam logic [AW-1:0] A_OFL = AW'('h008);
  localparam logic [AW-1:0] A_OFH = AW'('h00C);
  localparam logic [AW-1:0] A_CVL = AW'('h010);
  localparam logic [AW-1:0] A_CVH = AW'('h014);
  localparam logic [AW-1:0] A_ID  = AW'('hFCC);
  localparam logic [AW-1:0] A_RFR = AW'('h000);
  localparam int PW = 32 + PHW;

  logic           en, ws0, ws1, irq_q;
  logic [31:0]    off_lo, cmp_lo, cmp_hi;
  logic [PHW-1:0] off_hi;
  logic [CW-1:0]  deadline;

  wire wr_c   = cf_sel & wr_en;
  wire wr_ctl = wr_c && addr == A_CTL;
  wire wr_ofl = wr_c && addr == A_OFL;
  wire wr_ofh = wr_c && addr == A_OFH;
  wire wr_cvl = wr_c && addr == A_CVL;
  wire wr_cvh = wr_c && addr == A_CVH;
  wire wr_rfr = rf_sel && !cf_sel && wr_en && addr == A_RFR;

  wire           cfg_wr  = wr_ctl | wr_ofl | wr_ofh;
  wire           refresh = cfg_wr | wr_rfr;
  wire           nxt_en  = wr_ctl ? wdata[0] : en;
  wire [31:0]    nxt_ofl = wr_ofl ? wdata : off_lo;
  wire [PHW-1:0] nxt_ofh = wr_ofh ? wdata[PHW-1:0] : off_hi;
  wire [PW-1:0]  period  = {nxt_ofh, nxt_ofl};
  wire [CW-1:0]  new_dl  = sys_cnt + CW'(period);
  wire           expired = en && (sys_cnt >= deadline);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; ws0 <= 1'b0; ws1 <= 1'b0; irq_q <= 1'b0;
      off_lo <= '0; off_hi <= '0; cmp_lo <= '0; cmp_hi <= '0;
      deadline <= '0;
    end else begin
      if (wr_ofl) off_lo <= wdata;
      if (wr_ofh) off_hi <= wdata[PHW-1:0];
      if (wr_cvl) cmp_lo <= wdata;
      if (wr_cvh) cmp_hi <= wdata;
      if (refresh) begin
        en  <= nxt_en;
        ws0 <= 1'b0;
        ws1 <= 1'b0;
        if (cfg_wr) irq_q <= 1'b0;
        if (nxt_en) begin
          deadline <= new_dl;
          cmp_lo   <= new_dl[31:0];
          cmp_hi   <= new_dl[63:32];
        end
      end else if (expired) begin
        if (!ws0) begin
          ws0      <= 1'b1;
          irq_q    <= 1'b1;
          deadline <= new_dl;
        end else begin
          ws1 <= 1'b1;
        end
      end
    end
  end

  assign irq     = irq_q;
  assign rst_req = ws1;

  always_comb begin
    rdata = '0;
    if (rd_en && cf_sel) begin
      case (addr)
        A_CTL:   rdata = {29'd0, ws1, ws0, en};
        A_OFL:   rdata = off_lo;
        A_OFH:   rdata = 32'(off_hi);
        A_CVL:   rdata = cmp_lo;
        A_CVH:   rdata = cmp_hi;
        A_ID:    rdata = ID_WORD;
        default: rdata = '0;
      endcase
    end else if (rd_en && rf_sel && addr == A_ID) begin
      rdata = ID_WORD;
    end
  end

  p_stage2_after_stage1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(ws0));
  p_ctl_write_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !irq);
  p_refresh_drops_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rfr |=> !rst_req);
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en) && $past(sys_cnt) >= $past(deadline));
  p_stage1_keeps_compare_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0) && !$past(wr_cvl | wr_cvh) |-> $stable({cmp_hi, cmp_lo}));
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        rf_sel = 1'b0, cf_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] ID = 32'h0002_0A57;

  always #2 clk = ~clk;

  wdog_two_stage u0 (.clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .rf_sel(rf_sel),
    .cf_sel(cf_sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rst_req(rst_req));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit rf, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    rf_sel = rf; cf_sel = !rf; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    rf_sel = 0; cf_sel = 0; wr_en = 0;
  endtask

  task automatic rd(bit rf, logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rf_sel = rf; cf_sel = !rf; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rf_sel = 0; cf_sel = 0; rd_en = 0;
  endtask

  task automatic set_cnt(logic [63:0] c);
    @(negedge clk); sys_cnt = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    rd(0, 12'h000, d); chk("R9 ctl", d, 0);
    rd(0, 12'h008, d); chk("R9 off_lo", d, 0);
    rd(0, 12'h014, d); chk("R9 cmp_hi", d, 0);
    chk("R9 irq", irq, 0); chk("R9 rst_req", rst_req, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(0, 12'h00C, 32'hABCD_1234); rd(0, 12'h00C, d); chk("R1 off_hi mask", d, 32'h1234);
    wr(0, 12'h00C, 0); wr(0, 12'h008, 100);
    wr(0, 12'h000, 32'hFFFF_FFFE); rd(0, 12'h000, d); chk("R10 en bit only", d, 0);
    set_cnt(1000);
    wr(0, 12'h000, 32'hFFFF_FFFF); rd(0, 12'h000, d); chk("R10 enable", d, 1);
    rd(0, 12'h010, d); chk("R2 cmp_lo", d, 1100);
    rd(0, 12'h014, d); chk("R2 cmp_hi", d, 0);
  endtask

  task automatic t_stages();
    logic [31:0] d;
    set_cnt(1099); chk("R3 before deadline", irq, 0);
    set_cnt(1100); chk("R3 irq", irq, 1);
    rd(0, 12'h000, d); chk("R3 ws0", d, 3);
    rd(0, 12'h010, d); chk("R3 cmp kept", d, 1100);
    set_cnt(1199); chk("R4 before second", rst_req, 0);
    set_cnt(1200); chk("R4 rst_req", rst_req, 1);
    rd(0, 12'h000, d); chk("R4 ws1", d, 7);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    rd(1, 12'h000, d); chk("R8 refresh read", d, 0);
    rd(0, 12'h000, d); chk("R8 no side effect", d, 7);
    rd(1, 12'hFCC, d); chk("R8 id refresh", d, ID);
    rd(0, 12'hFCC, d); chk("R8 id control", d, ID);
  endtask

  task automatic t_refresh();
    logic [31:0] d;
    set_cnt(2000);
    wr(1, 12'h000, 32'h1234_5678);
    rd(0, 12'h000, d); chk("R5 flags cleared", d, 1);
    chk("R5 rst_req", rst_req, 0); chk("R5 irq kept", irq, 1);
    rd(0, 12'h010, d); chk("R5 cmp reload", d, 2100);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    wr(0, 12'h010, 5); wr(0, 12'h014, 0);
    rd(0, 12'h010, d); chk("R6 cmp stored", d, 5);
    rd(0, 12'h000, d); chk("R6 flags", d, 1); chk("R6 irq", irq, 1);
    set_cnt(2050); rd(0, 12'h000, d); chk("R6 deadline kept", d, 1);
    set_cnt(2100); rd(0, 12'h000, d); chk("R6 live deadline fires", d, 3);
  endtask

  task automatic t_offset();
    logic [31:0] d;
    wr(0, 12'h008, 50);
    chk("R11 irq cleared", irq, 0);
    rd(0, 12'h000, d); chk("R11 flags", d, 1);
    rd(0, 12'h010, d); chk("R11 new period", d, 2150);
  endtask

  task automatic t_carry();
    logic [31:0] d;
    wr(0, 12'h000, 0);
    set_cnt(64'hFFFF_FF00);
    wr(0, 12'h008, 32'h200); wr(0, 12'h00C, 2);
    rd(0, 12'h010, d); chk("R2 disabled no load", d, 2150);
    wr(0, 12'h000, 1);
    rd(0, 12'h010, d); chk("R2 carry lo", d, 32'h100);
    rd(0, 12'h014, d); chk("R1 48-bit hi", d, 3);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(0, 12'h000, 0);
    set_cnt(64'hFFFF_FFFF_0000_0000);
    repeat (5) @(negedge clk);
    chk("R7 no irq", irq, 0);
    rd(0, 12'h000, d); chk("R7 no flags", d, 0);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    wr(0, 12'h004, 32'hFFFF_FFFF);
    rd(0, 12'h000, d); chk("R12 write ignored", d, 0);
    rd(0, 12'h004, d); chk("R12 read zero", d, 0);
    rd(1, 12'h008, d); chk("R12 refresh frame read zero", d, 0);
  endtask

  initial begin
    t_reset(); t_regs(); t_stages(); t_reads(); t_refresh();
    t_compare(); t_offset(); t_carry(); t_disabled(); t_undef(); t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule